// File: doc/BRIEF.md
# Logical Immediate Mask Expander

This block turns the compact 13-bit logical-immediate code into the full masks that a logical datapath uses. The code consists of a one-bit element-size extension, a 6-bit rotate field and a 6-bit size/run field. From these the block produces two 64-bit outputs. The wide mask is a run of ones that is rotated inside an element and copied across the word. The test mask is an unrotated run, copied the same way.

The element size comes from the leading one of the extension bit placed above the inverted size/run field. Only the low bits of both fields, up to that size, take part. Several codes have no meaning, and the block flags them. A size select picks a 32-bit or 64-bit datapath. A qualifier marks the immediate form, which forbids an element made entirely of ones.

By default the outputs are registered. A result appears one clock after an input beat qualified by `in_valid`. The masks and the reserved flag always appear together.

Top module: `lim_mask_expander`

## Requirements
- R1: Let len be the index of the highest set bit of the 7-bit value {n_bit, ~size_field}. Then levels is a mask of len low ones, S = size_field & levels and esize = 2^len. With rot_field & levels equal to zero, every esize-bit element of wmask holds S+1 low ones.
- R2: wmask is the replicated pattern of R1 rotated right over the full 64 bits by R = rot_field & levels.
- R3: With d = (S − R) & levels, tmask is a run of d+1 low ones in every esize-bit element, with no rotation.
- R4: A code whose value {n_bit, ~size_field} has no set bit above bit 0 (len < 1) is reserved.
- R5: When imm_form is 1, a code with S equal to levels is reserved. When imm_form is 0, the same code is accepted and gives all-ones elements.
- R6: When wide is 0 (32-bit) and n_bit is 1, the code is reserved.
- R7: When wide is 0, bits 63..32 of wmask and tmask are 0.
- R8: When reserved is 1, wmask and tmask are both 0.
- R9: out_valid is in_valid delayed by one clock. The masks and reserved belong to that same accepted beat. They hold their values while in_valid is 0.
- R10: While rst_n is low, out_valid, wmask, tmask and reserved are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input code for capture |
| n_bit | input | 1 | Element-size extension bit |
| rot_field | input | 6 | Rotate amount field |
| size_field | input | 6 | Element size and run-length field |
| imm_form | input | 1 | 1 = immediate form, all-ones element reserved |
| wide | input | 1 | 1 = 64-bit datapath, 0 = 32-bit |
| out_valid | output | 1 | Result valid |
| wmask | output | 64 | Rotated, replicated run mask |
| tmask | output | 64 | Unrotated, replicated test mask |
| reserved | output | 1 | Code is reserved; masks forced to zero |

## Verification
Each mistake has its own signature at the ports. A wrong leading-one detection changes the element period, so the repeat distance of both masks is wrong at once. A wrong rotate stage moves the wmask run, while tmask stays correct. A wrong subtraction for d changes only tmask. A lost reserved term leaves nonzero masks where zeros are due.

Every error of this kind shows up on the first result cycle after the offending code is accepted. The sweep applies every code under every size and form setting, one code per clock. Any defect is therefore reported within one cycle of the first code that exposes it.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int unsigned FIELD_W_DEF = 6;

  typedef enum logic {
    SZ_NARROW = 1'b0,
    SZ_WIDE   = 1'b1
  } width_sel_e;
endpackage

// File: rtl/lim_field_decode.sv
module lim_field_decode #(
  parameter int unsigned FIELD_W = lim_pkg::FIELD_W_DEF
) (
  input  logic               n_bit,
  input  logic [FIELD_W-1:0] rot_field,
  input  logic [FIELD_W-1:0] size_field,
  input  logic               imm_form,
  input  logic               wide,
  output logic [FIELD_W-1:0] levels,
  output logic [FIELD_W-1:0] s_val,
  output logic [FIELD_W-1:0] r_val,
  output logic [FIELD_W-1:0] d_val,
  output logic               rsvd
);
  logic [FIELD_W:0] code;
  logic             rsvd_len, rsvd_ones, rsvd_narrow;

  assign code = {n_bit, ~size_field};

  // levels bit j is set when some code bit above j is set
  for (genvar j = 0; j < FIELD_W; j++) begin : g_lvl
    assign levels[j] = |code[FIELD_W:j+1];
  end

  always_comb begin
    s_val       = size_field & levels;
    r_val       = rot_field & levels;
    d_val       = (s_val - r_val) & levels;
    rsvd_len    = ~levels[0];
    rsvd_ones   = imm_form & (s_val == levels);
    rsvd_narrow = (wide == lim_pkg::SZ_NARROW) & n_bit;
    rsvd        = rsvd_len | rsvd_ones | rsvd_narrow;
  end
endmodule

// File: rtl/lim_run_fill.sv
module lim_run_fill #(
  parameter int unsigned FIELD_W = lim_pkg::FIELD_W_DEF,
  localparam int unsigned DATA_W = 1 << FIELD_W
) (
  input  logic [FIELD_W-1:0] levels,
  input  logic [FIELD_W-1:0] count,
  output logic [DATA_W-1:0]  run
);
  // bit i sits at position (i & levels) inside its element
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [FIELD_W-1:0] IDX = i[FIELD_W-1:0];
    assign run[i] = ((IDX & levels) <= count);
  end
endmodule

// File: rtl/lim_rotr.sv
module lim_rotr #(
  parameter int unsigned FIELD_W = lim_pkg::FIELD_W_DEF,
  localparam int unsigned DATA_W = 1 << FIELD_W
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [FIELD_W-1:0] amount,
  output logic [DATA_W-1:0]  data_out
);
  logic [DATA_W-1:0] stage [FIELD_W+1];

  assign stage[0] = data_in;

  for (genvar k = 0; k < FIELD_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign stage[k+1] = amount[k] ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]}
                                  : stage[k];
  end

  assign data_out = stage[FIELD_W];
endmodule

// File: rtl/lim_mask_expander.sv
module lim_mask_expander #(
  parameter int unsigned FIELD_W = lim_pkg::FIELD_W_DEF,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DATA_W = 1 << FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               n_bit,
  input  logic [FIELD_W-1:0] rot_field,
  input  logic [FIELD_W-1:0] size_field,
  input  logic               imm_form,
  input  logic               wide,
  output logic               out_valid,
  output logic [DATA_W-1:0]  wmask,
  output logic [DATA_W-1:0]  tmask,
  output logic               reserved
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [FIELD_W-1:0] levels, s_val, r_val, d_val;
  logic               rsvd_c;
  logic [DATA_W-1:0]  w_run, w_rot, t_run, keep;
  logic [DATA_W-1:0]  nxt_wmask, nxt_tmask;

  lim_field_decode #(.FIELD_W(FIELD_W)) u_dec (
    .n_bit      (n_bit),
    .rot_field  (rot_field),
    .size_field (size_field),
    .imm_form   (imm_form),
    .wide       (wide),
    .levels     (levels),
    .s_val      (s_val),
    .r_val      (r_val),
    .d_val      (d_val),
    .rsvd       (rsvd_c)
  );

  lim_run_fill #(.FIELD_W(FIELD_W)) u_wfill (
    .levels (levels),
    .count  (s_val),
    .run    (w_run)
  );

  lim_rotr #(.FIELD_W(FIELD_W)) u_rot (
    .data_in  (w_run),
    .amount   (r_val),
    .data_out (w_rot)
  );

  lim_run_fill #(.FIELD_W(FIELD_W)) u_tfill (
    .levels (levels),
    .count  (d_val),
    .run    (t_run)
  );

  always_comb begin
    keep      = (wide == lim_pkg::SZ_WIDE) ? {DATA_W{1'b1}}
                                           : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    nxt_wmask = rsvd_c ? '0 : (w_rot & keep);
    nxt_tmask = rsvd_c ? '0 : (t_run & keep);
  end

  if (OUT_REG) begin : g_reg
    logic              q_vld, q_rsvd;
    logic [DATA_W-1:0] q_wmask, q_tmask;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_vld <= 1'b0;
      end else begin
        q_vld <= in_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_wmask <= '0;
        q_tmask <= '0;
        q_rsvd  <= 1'b0;
      end else if (in_valid) begin
        q_wmask <= nxt_wmask;
        q_tmask <= nxt_tmask;
        q_rsvd  <= rsvd_c;
      end
    end

    assign out_valid = q_vld;
    assign wmask     = q_wmask;
    assign tmask     = q_tmask;
    assign reserved  = q_rsvd;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign wmask     = nxt_wmask;
    assign tmask     = nxt_tmask;
    assign reserved  = rsvd_c;
  end
endmodule

// File: rtl/lim_mask_expander_chk.sv
module lim_mask_expander_chk #(
  parameter int unsigned FIELD_W = lim_pkg::FIELD_W_DEF,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned DATA_W = 1 << FIELD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               n_bit,
  input logic [FIELD_W-1:0] rot_field,
  input logic [FIELD_W-1:0] size_field,
  input logic               imm_form,
  input logic               wide,
  input logic               out_valid,
  input logic [DATA_W-1:0]  wmask,
  input logic [DATA_W-1:0]  tmask,
  input logic               reserved
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic               a_n, a_imm, a_wide;
  logic [FIELD_W-1:0] a_size;

  if (OUT_REG) begin : g_align
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_n    <= 1'b0;
        a_imm  <= 1'b0;
        a_wide <= 1'b0;
        a_size <= '0;
      end else if (in_valid) begin
        a_n    <= n_bit;
        a_imm  <= imm_form;
        a_wide <= wide;
        a_size <= size_field;
      end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);  // R9
  end else begin : g_align
    assign a_n    = n_bit;
    assign a_imm  = imm_form;
    assign a_wide = wide;
    assign a_size = size_field;
  end

  logic unused_rot;
  assign unused_rot = ^rot_field;

  AST_RSVD_ZERO_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reserved) |-> (wmask == '0 && tmask == '0));  // R8
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !a_wide) |-> (wmask[DATA_W-1:HALF_W] == '0 && tmask[DATA_W-1:HALF_W] == '0));  // R7
  AST_NARROW_EXT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !a_wide && a_n) |-> reserved);  // R6
  AST_LEN_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !a_n && (&a_size[FIELD_W-1:1])) |-> reserved);  // R4
  AST_IMM_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !reserved && a_imm) |-> (wmask != '1));  // R5
  AST_TMASK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !reserved) |-> tmask[0]);  // R3
  AST_WMASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !reserved) |-> ($countones(wmask) != 0));  // R1
endmodule

bind lim_mask_expander lim_mask_expander_chk #(
  .FIELD_W (FIELD_W),
  .OUT_REG (OUT_REG)
) u_chk (.*);

// File: tb/lim_mask_expander_bench.sv
module lim_mask_expander_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        n_bit;
  logic [5:0]  rot_field;
  logic [5:0]  size_field;
  logic        imm_form;
  logic        wide;
  logic        out_valid;
  logic [63:0] wmask;
  logic [63:0] tmask;
  logic        reserved;

  int checks;
  int errors;

  lim_mask_expander u_lim_mask_expander (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .n_bit      (n_bit),
    .rot_field  (rot_field),
    .size_field (size_field),
    .imm_form   (imm_form),
    .wide       (wide),
    .out_valid  (out_valid),
    .wmask      (wmask),
    .tmask      (tmask),
    .reserved   (reserved)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference computed from the requirements
  task automatic ref_model(input logic n, input logic [5:0] rf, input logic [5:0] sf,
                           input logic immf, input logic wd,
                           output logic [63:0] ew, output logic [63:0] et, output logic er);
    logic [6:0]  val;
    int          len, lv, s, r, d, es;
    logic [63:0] rep;
    val = {n, ~sf};
    len = -1;
    for (int b = 6; b >= 0; b--) if (val[b] && len < 0) len = b;
    er = 1'b0;
    ew = '0;
    et = '0;
    if (len < 1) begin
      er = 1'b1;
    end else begin
      lv = (1 << len) - 1;
      s  = int'(sf) & lv;
      r  = int'(rf) & lv;
      d  = (s - r) & lv;
      es = 1 << len;
      if (immf && s == lv) er = 1'b1;
      if (!wd && n) er = 1'b1;
      for (int i = 0; i < 64; i++) rep[i] = ((i % es) <= s);
      for (int i = 0; i < 64; i++) ew[i] = rep[(i + r) % 64];
      for (int i = 0; i < 64; i++) et[i] = ((i % es) <= d);
      if (!wd) begin
        ew[63:32] = '0;
        et[63:32] = '0;
      end
      if (er) begin
        ew = '0;
        et = '0;
      end
    end
  endtask

  task automatic apply(input logic n, input logic [5:0] rf, input logic [5:0] sf,
                       input logic immf, input logic wd);
    n_bit      = n;
    rot_field  = rf;
    size_field = sf;
    imm_form   = immf;
    wide       = wd;
    in_valid   = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0] ew, et;
    logic        er;
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    n_bit      = 1'b0;
    rot_field  = '0;
    size_field = '0;
    imm_form   = 1'b0;
    wide       = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
    chk(wmask == '0, "R10 wmask in reset", wmask, 64'd0);
    chk(tmask == '0, "R10 tmask in reset", tmask, 64'd0);
    chk(reserved == 1'b0, "R10 reserved in reset", 64'(reserved), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed: 64-bit element, single one
    apply(1'b1, 6'd0, 6'd0, 1'b1, 1'b1);
    chk(wmask == 64'h1, "R1 single one", wmask, 64'h1);
    // R1 directed: 2-bit elements
    apply(1'b0, 6'd0, 6'b111100, 1'b1, 1'b1);
    chk(wmask == 64'h5555555555555555, "R1 two-bit elements", wmask, 64'h5555555555555555);
    // R2 and R3 directed: 32-bit element, 8 ones rotated by 4
    apply(1'b0, 6'd4, 6'b000111, 1'b1, 1'b1);
    chk(wmask == 64'hF000000FF000000F, "R2 rotate in element", wmask, 64'hF000000FF000000F);
    chk(tmask == 64'h0000000F0000000F, "R3 unrotated run", tmask, 64'h0000000F0000000F);
    // R5 non-immediate all-ones element
    apply(1'b0, 6'd0, 6'b111101, 1'b0, 1'b1);
    chk(wmask == '1 && !reserved, "R5 all ones accepted", wmask, '1);
    apply(1'b0, 6'd0, 6'b111101, 1'b1, 1'b1);
    chk(reserved == 1'b1, "R5 all ones reserved", 64'(reserved), 64'd1);
    // R6 narrow with extension bit
    apply(1'b1, 6'd0, 6'd0, 1'b1, 1'b0);
    chk(reserved == 1'b1 && wmask == '0, "R6 narrow ext reserved", 64'(reserved), 64'd1);

    // exhaustive sweep over every code, form and size
    for (int wd = 0; wd < 2; wd++) begin
      for (int fm = 0; fm < 2; fm++) begin
        for (int c = 0; c < 8192; c++) begin
          logic [12:0] cv;
          cv = 13'(c);
          apply(cv[12], cv[11:6], cv[5:0], 1'(fm), 1'(wd));
          ref_model(cv[12], cv[11:6], cv[5:0], 1'(fm), 1'(wd), ew, et, er);
          chk(out_valid == 1'b1, "R9 out_valid", 64'(out_valid), 64'd1);
          chk(reserved == er, "R4,R5,R6 reserved flag", 64'(reserved), 64'(er));
          chk(wmask == ew, "R1,R2,R7,R8 wmask", wmask, ew);
          chk(tmask == et, "R3,R7,R8 tmask", tmask, et);
        end
      end
    end

    // R9 hold while in_valid is low
    apply(1'b0, 6'd4, 6'b000111, 1'b1, 1'b1);
    in_valid   = 1'b0;
    n_bit      = 1'b1;
    size_field = 6'd0;
    rot_field  = 6'd0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 out_valid drops", 64'(out_valid), 64'd0);
    chk(wmask == 64'hF000000FF000000F, "R9 wmask held", wmask, 64'hF000000FF000000F);
    chk(tmask == 64'h0000000F0000000F, "R9 tmask held", tmask, 64'h0000000F0000000F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule